// File: doc/BRIEF.md
# Interrupt Aggregator with Prescaled Timer

This block gathers ten peripheral interrupt requests into a sticky pending register and reduces them to a single processor interrupt line. The line is gated by a global enable and by six group enables. A mode bit picks one of two output styles. In level style the line stays high while any enabled request is pending. In pulse style it goes high for one clock each time the gated request set goes from empty to non-empty.

A time base is built in. A power-of-two prescaler divides the clock by 2^n, with n from 0 to 14. A terminal-count timer then counts the prescaled strobes and emits a one-clock tick each time it reaches the programmed terminal value. The tick is latched as an eleventh pending source, so the timer can also raise the interrupt line. Software reaches four registers through a simple word-addressed port. Reads return data one cycle after the read strobe.

Top module: `irq_agg`

## Requirements
- R1: After reset the mask, pending, prescale and terminal registers read 0, and `cpu_irq` and `tick_out` are 0.
- R2: A high level on `src_irq[i]` at a clock edge sets pending bit i. The bit stays set after the source drops. The pending bit order is: GPIO banks A..D in bits 0..3, three LED channels in bits 4..6, SPI in bit 7, SMBus in bit 8, one-wire in bit 9, and the timer tick in bit 10.
- R3: Writing 1 to a pending bit at offset 0x04 clears it, and writing 0 leaves it unchanged. If the source is still high in the cycle of the write, the set wins and the bit stays 1.
- R4: While mask bit 0 (global enable) is 0, `cpu_irq` stays 0 whatever is pending.
- R5: Mask bits 2..7 enable groups 0..5 (1 = enabled). Group 0 is pending bits 0..3, group 1 is bits 4..6, group 2 is bit 7, group 3 is bit 8, group 4 is bit 9 and group 5 is bit 10. A pending bit in a disabled group does not raise `cpu_irq`.
- R6: With mask bit 1 = 0 (level style), `cpu_irq` equals the gated OR of the pending bits, delayed by one register stage.
- R7: With mask bit 1 = 1 (pulse style), `cpu_irq` is high for exactly one clock, one cycle after the gated OR rises. It stays low while the OR remains high.
- R8: The prescale register at 0x08 holds n in bits 3..0 and the time-base enable in bit 4. A written n above 14 is stored as 14.
- R9: With the time base enabled, `tick_out` pulses for one clock every (T+1)·2^n cycles, where T is the terminal register at 0x0C. The first tick comes (T+1)·2^n cycles after the enabling write.
- R10: While the time-base enable is 0, `tick_out` stays 0.
- R11: Each tick sets pending bit 10. Through group 5, that bit can raise `cpu_irq`.
- R12: Register offsets are 0x00 mask (8 bits), 0x04 pending, 0x08 prescale and 0x0C terminal (16 bits). Address bits 1..0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | 10 | Peripheral interrupt requests, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| cpu_irq | output | 1 | Processor interrupt line |
| tick_out | output | 1 | One-clock periodic timer tick |

## Verification
The bench works from the latency of each path:
- A source high at edge E shows as pending after E, and `cpu_irq` reacts at E+1.
- A mask write at edge E changes `cpu_irq` at E+1.
- Read data appears after the edge that takes the read strobe.
- The first tick comes (T+1)·2^n edges after the enabling write.

Stimulus is driven on falling edges. Outputs are sampled on the falling edge that follows the edge at which they are due. Register reads go through the scoreboard queue, whose monitor pops one expected word in the half cycle after each read strobe. Tick spacing is measured by counting falling edges between pulses.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_SRC   = 10;
  localparam int NUM_GRP   = 6;
  localparam int STAT_W    = NUM_SRC + 1;
  localparam int TICK_BIT  = NUM_SRC;
  localparam int MASK_W    = 2 + NUM_GRP;
  localparam int GEN_BIT   = 0;
  localparam int MODE_BIT  = 1;
  localparam int GRP_LSB   = 2;

  typedef enum logic [1:0] {
    RSEL_MASK = 2'd0,
    RSEL_PEND = 2'd1,
    RSEL_PRE  = 2'd2,
    RSEL_TERM = 2'd3
  } rsel_e;

  function automatic int grp_of(input int b);
    if (b < 4)       return 0;
    else if (b < 7)  return 1;
    else if (b == 7) return 2;
    else if (b == 8) return 3;
    else if (b == 9) return 4;
    else             return 5;
  endfunction
endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int PRE_W   = 4,
  parameter int PRE_MAX = 14,
  parameter int TERM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [STAT_W-1:0] pend_q,
  output logic [MASK_W-1:0] mask_q,
  output logic [STAT_W-1:0] pend_clr,
  output logic [PRE_W-1:0]  pre_n,
  output logic              pre_en,
  output logic [TERM_W-1:0] term_q,
  output logic [DATA_W-1:0] bus_rdata
);
  rsel_e             sel;
  logic [PRE_W-1:0]  n_wr;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_addr;

  assign sel         = rsel_e'(bus_addr[3:2]);
  assign n_wr        = bus_wdata[PRE_W-1:0];
  assign unused_addr = ^bus_addr[1:0];
  assign pend_clr    = (bus_wr && sel == RSEL_PEND) ? bus_wdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      pre_n  <= '0;
      pre_en <= 1'b0;
      term_q <= '0;
    end else if (bus_wr) begin
      case (sel)
        RSEL_MASK: mask_q <= bus_wdata[MASK_W-1:0];
        RSEL_PRE: begin
          pre_n  <= (n_wr > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : n_wr;
          pre_en <= bus_wdata[PRE_W];
        end
        RSEL_TERM: term_q <= bus_wdata[TERM_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      RSEL_MASK: rd_mux = DATA_W'(mask_q);
      RSEL_PEND: rd_mux = DATA_W'(pend_q);
      RSEL_PRE:  rd_mux = DATA_W'({pre_en, pre_n});
      default:   rd_mux = DATA_W'(term_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_agg_pend.sv
module irq_agg_pend
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               tick,
  input  logic [STAT_W-1:0]  pend_clr,
  output logic [STAT_W-1:0]  pend_q
);
  logic [STAT_W-1:0] set_vec;

  assign set_vec = {tick, src_irq};

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~pend_clr) | set_vec;
  end
endmodule

// File: rtl/irq_agg_timebase.sv
module irq_agg_timebase #(
  parameter int PRE_W   = 4,
  parameter int PRE_MAX = 14,
  parameter int TERM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre_en,
  input  logic [PRE_W-1:0]  pre_n,
  input  logic [TERM_W-1:0] term_q,
  output logic              tick
);
  localparam int CNT_W = (PRE_MAX < 1) ? 1 : PRE_MAX;

  logic [CNT_W-1:0]  pcnt;
  logic [CNT_W-1:0]  pmask;
  logic              strobe;
  logic [TERM_W-1:0] tcnt;

  assign pmask  = CNT_W'((32'd1 << pre_n) - 32'd1);
  assign strobe = pre_en && ((pcnt & pmask) == pmask);

  always_ff @(posedge clk) begin
    if (rst || !pre_en) pcnt <= '0;
    else if (strobe)    pcnt <= '0;
    else                pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !pre_en) begin
      tcnt <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (strobe) begin
        if (tcnt >= term_q) begin
          tcnt <= '0;
          tick <= 1'b1;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_agg_out.sv
module irq_agg_out
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] pend_q,
  input  logic [MASK_W-1:0] mask_q,
  output logic              cpu_irq
);
  logic [STAT_W-1:0] en_bits;
  logic              any_req;
  logic              any_prev;

  for (genvar b = 0; b < STAT_W; b++) begin : g_grp
    assign en_bits[b] = mask_q[GRP_LSB + grp_of(b)];
  end

  assign any_req = mask_q[GEN_BIT] && |(pend_q & en_bits);

  always_ff @(posedge clk) begin
    if (rst) begin
      any_prev <= 1'b0;
      cpu_irq  <= 1'b0;
    end else begin
      any_prev <= any_req;
      cpu_irq  <= mask_q[MODE_BIT] ? (any_req && !any_prev) : any_req;
    end
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int PRE_W   = 4,
  parameter int PRE_MAX = 14,
  parameter int TERM_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               cpu_irq,
  output logic               tick_out
);
  logic [MASK_W-1:0] mask_q;
  logic [STAT_W-1:0] pend_q;
  logic [STAT_W-1:0] pend_clr;
  logic [PRE_W-1:0]  pre_n;
  logic              pre_en;
  logic [TERM_W-1:0] term_q;

  irq_agg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W),
    .PRE_MAX(PRE_MAX), .TERM_W(TERM_W)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_q(pend_q),
    .mask_q(mask_q), .pend_clr(pend_clr), .pre_n(pre_n),
    .pre_en(pre_en), .term_q(term_q), .bus_rdata(bus_rdata)
  );

  irq_agg_pend u_pend (
    .clk(clk), .rst(rst), .src_irq(src_irq), .tick(tick_out),
    .pend_clr(pend_clr), .pend_q(pend_q)
  );

  irq_agg_timebase #(
    .PRE_W(PRE_W), .PRE_MAX(PRE_MAX), .TERM_W(TERM_W)
  ) u_tb (
    .clk(clk), .rst(rst), .pre_en(pre_en), .pre_n(pre_n),
    .term_q(term_q), .tick(tick_out)
  );

  irq_agg_out u_out (
    .clk(clk), .rst(rst), .pend_q(pend_q), .mask_q(mask_q),
    .cpu_irq(cpu_irq)
  );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int PRE_W   = 4,
  parameter int PRE_MAX = 14
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_irq,
  input logic               cpu_irq,
  input logic               tick_out,
  input logic [MASK_W-1:0]  mask_q,
  input logic [STAT_W-1:0]  pend_q,
  input logic [STAT_W-1:0]  pend_clr,
  input logic [PRE_W-1:0]   pre_n,
  input logic               pre_en
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_irq && !tick_out)); // R1

  AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pend_q[NUM_SRC-1:0] & $past(src_irq)) == $past(src_irq))); // R2

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|($past(pend_q) & ~pend_q)) |-> (|$past(pend_clr))); // R3

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
    !$past(mask_q[GEN_BIT]) |-> !cpu_irq); // R4

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq && mask_q[MODE_BIT]) |=> !cpu_irq); // R7

  AST_PRE_CLAMP: assert property (@(posedge clk) disable iff (rst)
    pre_n <= PRE_W'(PRE_MAX)); // R8

  AST_TIMEBASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(pre_en) |-> !tick_out); // R10
endmodule

bind irq_agg irq_agg_chk #(.PRE_W(PRE_W), .PRE_MAX(PRE_MAX)) u_chk (
  .clk(clk), .rst(rst), .src_irq(src_irq), .cpu_irq(cpu_irq),
  .tick_out(tick_out), .mask_q(mask_q), .pend_q(pend_q),
  .pend_clr(pend_clr), .pre_n(pre_n), .pre_en(pre_en)
);

// File: tb/irq_agg_test.sv
`timescale 1ns/1ps
module irq_agg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  src_irq = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cpu_irq;
  logic        tick_out;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_q = 1'b0;

  always #2.5 clk = ~clk;

  irq_agg uut (
    .clk(clk), .rst(rst), .src_irq(src_irq), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .tick_out(tick_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // driver tasks: called and returning on a falling edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_src(input logic [9:0] v);
    src_irq = v;
    @(negedge clk);
    src_irq = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: data is due in the half cycle after the edge that took the read
  always @(posedge clk) rd_q <= bus_rd;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard read with empty queue actual=0x%0h expected=none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), 32'(bus_rdata), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    int cnt;
    int nt;
    idle(4);
    rst = 1'b0;
    // R1 reset state
    chk("R1 cpu_irq", 32'(cpu_irq), 0);
    chk("R1 tick_out", 32'(tick_out), 0);
    rd(4'h0, 16'h0000, "R1 mask");
    rd(4'h4, 16'h0000, "R1 pending");
    rd(4'h8, 16'h0000, "R1 prescale");
    rd(4'hC, 16'h0000, "R1 terminal");
    // R12 offsets and widths, low address bits ignored
    wr(4'hC, 16'h1234);
    wr(4'h0, 16'hFFA5);
    rd(4'hD, 16'h1234, "R12 terminal");
    rd(4'h3, 16'h00A5, "R12 mask 8 bits");
    wr(4'h0, 16'h0000);
    wr(4'hC, 16'h0000);
    // R2 capture and order: SMBus bit 8, then GPIO A bit 0 and one-wire bit 9
    pulse_src(10'h100);
    rd(4'h4, 16'h0100, "R2 smbus bit");
    pulse_src(10'h201);
    rd(4'h4, 16'h0301, "R2 sticky set");
    // R3 write one to clear, set wins
    wr(4'h4, 16'h0100);
    rd(4'h4, 16'h0201, "R3 clear one bit");
    src_irq = 10'h001;
    wr(4'h4, 16'h0201);
    rd(4'h4, 16'h0001, "R3 set wins over clear");
    src_irq = '0;
    wr(4'h4, 16'h0001);
    rd(4'h4, 16'h0000, "R3 cleared");
    // R4 global enable gate, R6 level style
    pulse_src(10'h080);
    wr(4'h0, 16'h00FC);
    idle(4);
    chk("R4 gated off", 32'(cpu_irq), 0);
    wr(4'h0, 16'h00FD);
    chk("R6 one stage delay", 32'(cpu_irq), 0);
    idle(1);
    chk("R6 level high", 32'(cpu_irq), 1);
    idle(3);
    chk("R6 level held", 32'(cpu_irq), 1);
    wr(4'h4, 16'h0080);
    idle(1);
    chk("R6 level follows clear", 32'(cpu_irq), 0);
    // R5 groups: only group 1 (LEDs) enabled
    wr(4'h0, 16'h0009);
    pulse_src(10'h004);
    idle(3);
    chk("R5 group0 disabled", 32'(cpu_irq), 0);
    pulse_src(10'h020);
    idle(1);
    chk("R5 group1 enabled", 32'(cpu_irq), 1);
    wr(4'h0, 16'h0041);
    idle(1);
    chk("R5 group4 blocks others", 32'(cpu_irq), 0);
    pulse_src(10'h200);
    idle(1);
    chk("R5 group4 one-wire", 32'(cpu_irq), 1);
    wr(4'h0, 16'h0000);
    wr(4'h4, 16'h07FF);
    rd(4'h4, 16'h0000, "R3 clear all");
    // R7 pulse style with a held source
    wr(4'h0, 16'h00FF);
    src_irq = 10'h010;
    idle(1);
    chk("R7 not yet", 32'(cpu_irq), 0);
    idle(1);
    chk("R7 pulse", 32'(cpu_irq), 1);
    idle(1);
    chk("R7 pulse ends", 32'(cpu_irq), 0);
    idle(3);
    chk("R7 no repeat", 32'(cpu_irq), 0);
    src_irq = '0;
    wr(4'h0, 16'h0000);
    wr(4'h4, 16'h07FF);
    // R8 clamp
    wr(4'h8, 16'h001F);
    rd(4'h8, 16'h001E, "R8 clamp enabled");
    wr(4'h8, 16'h000F);
    rd(4'h8, 16'h000E, "R8 clamp disabled");
    // R10 disabled time base
    wr(4'h8, 16'h0000);
    wr(4'hC, 16'h0000);
    nt = 0;
    for (int i = 0; i < 20; i++) begin
      idle(1);
      if (tick_out) nt++;
    end
    chk("R10 no tick", 32'(nt), 0);
    wr(4'h4, 16'h07FF);
    // R9 n=2, T=3 -> 16 cycles
    wr(4'hC, 16'h0003);
    wr(4'h8, 16'h0012);
    cnt = 0;
    while (!tick_out && cnt < 100) begin idle(1); cnt++; end
    chk("R9 first tick delay", 32'(cnt), 16);
    idle(1);
    chk("R9 tick one cycle", 32'(tick_out), 0);
    cnt = 1;
    while (!tick_out && cnt < 100) begin idle(1); cnt++; end
    chk("R9 tick period", 32'(cnt), 16);
    // R11 tick latched as bit 10
    wr(4'h8, 16'h0000);
    rd(4'h4, 16'h0400, "R11 tick pending");
    wr(4'h0, 16'h0081);
    idle(1);
    chk("R11 group5 raises irq", 32'(cpu_irq), 1);
    wr(4'h0, 16'h0001);
    idle(1);
    chk("R5 group5 disabled", 32'(cpu_irq), 0);
    wr(4'h4, 16'h07FF);
    // R9 n=0, T=4 -> 5 cycles
    wr(4'hC, 16'h0004);
    wr(4'h8, 16'h0010);
    cnt = 0;
    while (!tick_out && cnt < 100) begin idle(1); cnt++; end
    chk("R9 first tick n0", 32'(cnt), 5);
    cnt = 0;
    do begin idle(1); cnt++; end while (!tick_out && cnt < 100);
    chk("R9 period n0", 32'(cnt), 5);
    wr(4'h8, 16'h0000);
    idle(3);
    chk("R9 scoreboard drained", 32'(exp_q.size()), 0);
    report();
  end
endmodule